// File: doc/BRIEF.md
# Stream-Fed Stereo Serial Audio Transmitter

This block turns a stream of packed stereo words into an I2S bit stream for a small audio DAC. One master clock drives the whole block. A frame counter divides that clock to produce the bit clock and the channel-select (word) clock. At 11.2896 MHz the output rate is 44.1 kHz, because one stereo frame lasts 256 master clocks. Each 32-bit input word holds both channels of one frame as 16-bit signed two's-complement samples. The upper half is the left channel and the lower half is the right channel.

The block fetches one word per frame from a FIFO-style slave port, a fixed number of master clocks before each left half starts. It never waits for data. If the source has nothing ready at the fetch instant, the block still plays the next frame, but with a deliberate click instead of the missing audio. An eight-bit thermometer meter rises on each missed fetch and falls on each good one. Each meter bit can drive an LED, so a builder can see how close the source runs to its real-time limit.

Top module: `i2s_stream_tx`

## Requirements
- R1: A synchronous reset holds bitClk, wordClk, serialData and streamRead at 0 and missLevel at 8'h00. The frame played right after reset is silent on both channels.
- R2: bitClk is mclk divided by 4. It is low for 2 mclk cycles and then high for 2, and the first half of each period after reset is low.
- R3: wordClk has a period of 256 mclk cycles. It is low (left channel) for the first 128 cycles after reset and high (right channel) for the next 128. It changes only when bitClk falls.
- R4: streamRead is a single-cycle pulse. It is high only while streamValid is high, and only in the cycle that lies 8 mclk cycles before the left half begins (frame phase 248 of 0..255). At most one word is consumed per frame.
- R5: A fetched word is played in the next frame. The left sample comes from bits [31:16] and the right sample from bits [15:0]. In each half, bit slot 1 carries the sample MSB and slots 1 to 16 carry the sample MSB first. Slot 0 and slots 17 to 31 are 0. serialData changes only when bitClk falls, so the receiver samples it on the rising edge.
- R6: With byte swapping enabled (the default), the two bytes of each 16-bit half are exchanged before transmission. An input left half of 16'h1234 is sent as 16'h3412.
- R7: A fetch with streamValid low does not stall the output. The next frame plays a left sample of full scale, 16'h7FFF, and a right sample of 16'h0000.
- R8: missLevel is a thermometer code. A missed fetch shifts it left and inserts a 1, saturating at 8'hFF. A good fetch shifts it right and inserts a 0, saturating at 8'h00. The new value is visible one cycle after the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256 times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| streamData | input | 32 | Stereo word: left sample in [31:16], right sample in [15:0] |
| streamValid | input | 1 | The source has a word ready |
| streamRead | output | 1 | Consume-strobe back to the source |
| bitClk | output | 1 | Serial bit clock |
| wordClk | output | 1 | Channel select: 0 for left, 1 for right |
| serialData | output | 1 | Serial sample data, MSB first |
| missLevel | output | 8 | Deadline-miss thermometer meter |

## Verification
Assertions check every cycle that the word clock and the serial data change only on a falling bit clock, and that the consume strobe never lasts two cycles. They also check that the meter stays a valid thermometer code and gains exactly one bit on each unsaturated miss. Only the bench scenarios can show what is actually sent. They decode the serial stream at each rising bit clock and compare the result with a queue of expected frames. This covers byte-swapped samples, the full-scale click after an underrun, the silent first frame and the zero padding. The same scenarios check the fetch phase and walk the meter into both saturation limits.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  // Strobes sent from the timing control to the sample datapath
  typedef struct packed {
    logic       load;      // word present at fetch instant
    logic       underrun;  // fetch instant with nothing available
    logic       bitStep;   // last mclk of a bit slot
    logic       nextRight; // channel of the coming slot
    logic [7:0] nextSlot;  // index of the coming slot within its half
  } ctrlStrobes_t;

endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int MCLK_PER_BIT   = 4,
  parameter int SLOTS_PER_HALF = 32,
  parameter int FETCH_LEAD     = 8,
  parameter int METER_W        = 8
) (
  input  logic               mclk,
  input  logic               rst,
  input  logic               streamValid,
  output logic               streamRead,
  output logic               bitClk,
  output logic               wordClk,
  output ctrlStrobes_t       strobes,
  output logic [METER_W-1:0] missLevel
);

  localparam int DIV_W     = $clog2(MCLK_PER_BIT);
  localparam int SLOT_W    = $clog2(SLOTS_PER_HALF);
  localparam int CNT_W     = DIV_W + SLOT_W + 1;
  localparam int FRAME_LEN = 1 << CNT_W;
  localparam int FETCH_AT  = FRAME_LEN - FETCH_LEAD;

  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] phaseNext;
  logic             fetchNow;

  assign phaseNext = phase + 1'b1;

  always_ff @(posedge mclk) begin
    if (rst) phase <= '0;
    else     phase <= phaseNext;
  end

  assign bitClk  = phase[DIV_W-1];
  assign wordClk = phase[CNT_W-1];

  assign fetchNow = !rst && (phase == CNT_W'(FETCH_AT));

  always_comb begin
    strobes           = '0;
    strobes.load      = fetchNow && streamValid;
    strobes.underrun  = fetchNow && !streamValid;
    strobes.bitStep   = &phase[DIV_W-1:0];
    strobes.nextRight = phaseNext[CNT_W-1];
    strobes.nextSlot  = 8'(phaseNext[CNT_W-2:DIV_W]);
  end

  assign streamRead = strobes.load;

  // Thermometer deadline meter
  always_ff @(posedge mclk) begin
    if (rst)                   missLevel <= '0;
    else if (strobes.load)     missLevel <= missLevel >> 1;
    else if (strobes.underrun) missLevel <= {missLevel[METER_W-2:0], 1'b1};
  end

  assert_word_edge_R3: assert property (@(posedge mclk) disable iff (rst)
    !$stable(wordClk) |-> $fell(bitClk));

  assert_single_read_R4: assert property (@(posedge mclk) disable iff (rst)
    streamRead |=> !streamRead);

  assert_meter_thermo_R8: assert property (@(posedge mclk) disable iff (rst)
    (missLevel & (missLevel + 1'b1)) == '0);

  assert_meter_rise_R8: assert property (@(posedge mclk) disable iff (rst)
    (strobes.underrun && !(&missLevel)) |=>
      $countones(missLevel) == $countones($past(missLevel)) + 1);

endmodule

// File: rtl/i2s_tx_datapath.sv
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int SWAP_BYTES = 1
) (
  input  logic                  mclk,
  input  logic                  rst,
  input  logic [2*SAMPLE_W-1:0] streamData,
  input  ctrlStrobes_t          strobes,
  input  logic                  bitClk,
  output logic                  serialData
);

  localparam int BYTES = SAMPLE_W / 8;
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam logic [SAMPLE_W-1:0] FULL_SCALE = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [SAMPLE_W-1:0] inLeft, inRight, swLeft, swRight;
  logic [SAMPLE_W-1:0] leftQ, rightQ, curSample;
  logic                bitPick;
  int                  slotNum;

  assign inLeft  = streamData[2*SAMPLE_W-1:SAMPLE_W];
  assign inRight = streamData[SAMPLE_W-1:0];

  generate
    if (SWAP_BYTES != 0) begin : g_swap
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign swLeft[8*b +: 8]  = inLeft[8*(BYTES-1-b) +: 8];
        assign swRight[8*b +: 8] = inRight[8*(BYTES-1-b) +: 8];
      end
    end else begin : g_pass
      assign swLeft  = inLeft;
      assign swRight = inRight;
    end
  endgenerate

  always_ff @(posedge mclk) begin
    if (rst) begin
      leftQ  <= '0;
      rightQ <= '0;
    end else if (strobes.load) begin
      leftQ  <= swLeft;
      rightQ <= swRight;
    end else if (strobes.underrun) begin
      leftQ  <= FULL_SCALE;
      rightQ <= '0;
    end
  end

  assign curSample = strobes.nextRight ? rightQ : leftQ;
  assign slotNum   = int'(strobes.nextSlot);

  always_comb begin
    bitPick = 1'b0;
    if (slotNum >= 1 && slotNum <= SAMPLE_W)
      bitPick = curSample[IDX_W'(SAMPLE_W - slotNum)];
  end

  always_ff @(posedge mclk) begin
    if (rst)                  serialData <= 1'b0;
    else if (strobes.bitStep) serialData <= bitPick;
  end

  assert_data_edge_R5: assert property (@(posedge mclk) disable iff (rst)
    !$stable(serialData) |-> $fell(bitClk));

  assert_fetch_excl_R4: assert property (@(posedge mclk) disable iff (rst)
    !(strobes.load && strobes.underrun));

endmodule

// File: rtl/i2s_stream_tx.sv
module i2s_stream_tx
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W       = 16,
  parameter int MCLK_PER_BIT   = 4,
  parameter int SLOTS_PER_HALF = 32,
  parameter int FETCH_LEAD     = 8,
  parameter int SWAP_BYTES     = 1,
  parameter int METER_W        = 8
) (
  input  logic                  mclk,
  input  logic                  rst,
  input  logic [2*SAMPLE_W-1:0] streamData,
  input  logic                  streamValid,
  output logic                  streamRead,
  output logic                  bitClk,
  output logic                  wordClk,
  output logic                  serialData,
  output logic [METER_W-1:0]    missLevel
);

  ctrlStrobes_t strobes;

  i2s_tx_ctrl #(
    .MCLK_PER_BIT  (MCLK_PER_BIT),
    .SLOTS_PER_HALF(SLOTS_PER_HALF),
    .FETCH_LEAD    (FETCH_LEAD),
    .METER_W       (METER_W)
  ) u_ctrl (
    .mclk       (mclk),
    .rst        (rst),
    .streamValid(streamValid),
    .streamRead (streamRead),
    .bitClk     (bitClk),
    .wordClk    (wordClk),
    .strobes    (strobes),
    .missLevel  (missLevel)
  );

  i2s_tx_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .SWAP_BYTES(SWAP_BYTES)
  ) u_dp (
    .mclk      (mclk),
    .rst       (rst),
    .streamData(streamData),
    .strobes   (strobes),
    .bitClk    (bitClk),
    .serialData(serialData)
  );

endmodule

// File: tb/sim_i2s_stream_tx.sv
module sim_i2s_stream_tx;

  logic        mclk = 1'b0;
  logic        rst  = 1'b1;
  logic [31:0] streamData  = 32'h1234_5678;
  logic        streamValid = 1'b1;
  logic        streamRead, bitClk, wordClk, serialData;
  logic [7:0]  missLevel;

  i2s_stream_tx u0 (
    .mclk(mclk), .rst(rst), .streamData(streamData), .streamValid(streamValid),
    .streamRead(streamRead), .bitClk(bitClk), .wordClk(wordClk),
    .serialData(serialData), .missLevel(missLevel)
  );

  always #5 mclk = ~mclk;

  int cyc = 0;
  always @(posedge mclk) cyc <= rst ? 0 : cyc + 1;

  int tests = 0, fails = 0, reads = 0;
  bit done = 0;

  typedef struct { logic [15:0] l; logic [15:0] r; string tag; } frame_t;
  frame_t expQ[$];
  logic [7:0]  meterModel = 8'h00;
  logic [15:0] curL, curR;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Read-strobe monitor (R4)
  always @(negedge mclk) if (!rst && streamRead) begin
    reads++;
    check((cyc % 256) == 248 && streamValid, "R4", "read phase",
          32'(cyc % 256), 32'd248);
  end

  // Clock monitor (R2, R3)
  always @(negedge mclk) if (!rst && !done) begin
    check(bitClk == ((cyc % 4) >= 2), "R2", "bitClk", 32'(bitClk), 32'((cyc % 4) >= 2));
    check(wordClk == ((cyc % 256) >= 128), "R3", "wordClk", 32'(wordClk),
          32'((cyc % 256) >= 128));
  end

  // Serial monitor / scoreboard (R1, R5, R6, R7)
  always @(negedge mclk) if (!rst && !done && (cyc % 4) == 2) begin
    automatic int slot  = (cyc / 4) % 32;
    automatic bit right = ((cyc / 128) % 2) == 1;
    automatic int frame = cyc / 256;
    if (slot >= 1 && slot <= 16) begin
      if (right) curR[16-slot] = serialData;
      else       curL[16-slot] = serialData;
    end else if (serialData !== 1'b0) begin
      check(0, "R5", "padding bit", 32'(serialData), 32'd0);
    end
    if (right && slot == 31) begin
      if (frame == 0) begin
        check({curL, curR} == 32'h0, "R1", "first frame silent", {curL, curR}, 32'h0);
      end else if (expQ.size() > 0) begin
        automatic frame_t e = expQ.pop_front();
        check(curL == e.l, e.tag, "left sample", 32'(curL), 32'(e.l));
        check(curR == e.r, e.tag, "right sample", 32'(curR), 32'(e.r));
      end
    end
  end

  // Driver: one call per frame
  task automatic driveFrame(input bit present, input logic [31:0] word, input string tag);
    frame_t e;
    int readsBefore;
    do @(negedge mclk); while ((cyc % 256) != 240);
    streamValid = present;
    streamData  = word;
    readsBefore = reads;
    e.tag = tag;
    if (present) begin
      e.l = swap16(word[31:16]);
      e.r = swap16(word[15:0]);
      meterModel = meterModel >> 1;
    end else begin
      e.l = 16'h7FFF;
      e.r = 16'h0000;
      meterModel = {meterModel[6:0], 1'b1};
    end
    expQ.push_back(e);
    do @(negedge mclk); while ((cyc % 256) != 250);
    check((reads - readsBefore) == int'(present), "R4", "reads this frame",
          32'(reads - readsBefore), 32'(present));
    check(missLevel == meterModel, "R8", "meter", 32'(missLevel), 32'(meterModel));
    streamValid = 1'b0;
    streamData  = 32'hDEAD_BEEF;
  endtask

  initial begin
    repeat (4) @(negedge mclk);
    // R1: reset state while the source offers data
    check(!bitClk && !wordClk && !serialData, "R1", "clocks/data in reset",
          {29'd0, bitClk, wordClk, serialData}, 32'd0);
    check(!streamRead, "R1", "no read in reset", 32'(streamRead), 32'd0);
    check(missLevel == 8'h00, "R1", "meter in reset", 32'(missLevel), 32'd0);
    rst = 1'b0;

    driveFrame(1, 32'h1234_ABCD, "R6");
    driveFrame(1, 32'h8000_7FFF, "R5");
    driveFrame(0, 32'h0,         "R7");
    driveFrame(1, 32'h0102_0304, "R6");
    driveFrame(1, 32'hFFFF_0001, "R5");
    for (int i = 0; i < 9; i++) driveFrame(0, 32'h0, "R7");
    check(missLevel == 8'hFF, "R8", "saturate high", 32'(missLevel), 32'hFF);
    for (int i = 0; i < 9; i++) driveFrame(1, 32'hA5C3_0F00 ^ 32'(i * 32'h0111_0222), "R5");
    check(missLevel == 8'h00, "R8", "saturate low", 32'(missLevel), 32'h00);
    driveFrame(0, 32'h0, "R7");
    driveFrame(1, 32'h55AA_AA55, "R6");
    repeat (600) @(negedge mclk);
    check(expQ.size() == 0, "R5", "all frames played", 32'(expQ.size()), 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL R4 watchdog: actual %h expected %h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule